// File: doc/BRIEF.md
# Five-Function Integer ALU with Flags

This block is the combinational arithmetic logic unit of a small load/store processor core. It takes two operands and a three-bit operation code. It returns a result word, a zero flag and a signed overflow flag. The five operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. A single adder carries all of the arithmetic. For subtraction, the second operand is inverted and a carry-in of one is forced.

Set-on-less-than uses that same subtractor. The top bit of the difference, corrected by the subtraction overflow, becomes bit 0 of the result. The zero flag lets the core test equality by subtracting and checking for an all-zero word. Overflow is only reported as a flag; the block raises no trap. There is no clock and no reset.

Top module: `int_alu`

## Requirements
- R1: Operation code 3'b000 returns the bitwise AND of `a` and `b`.
- R2: Operation code 3'b001 returns the bitwise OR of `a` and `b`.
- R3: Operation code 3'b010 returns `a + b` modulo 2^WIDTH.
- R4: Operation code 3'b110 returns `a - b` modulo 2^WIDTH, formed as `a + ~b + 1`.
- R5: Operation code 3'b111 returns 1 in bit 0 when `a` is less than `b` as signed two's complement numbers, otherwise 0. All higher result bits are 0. The answer is correct even when `a - b` overflows.
- R6: `zero` is 1 exactly when every result bit is 0. With subtraction this means `zero` is 1 exactly when `a` equals `b`.
- R7: For addition, `ovf` is 1 exactly when `a` and `b` have the same sign and the result's sign differs from it.
- R8: For subtraction, `ovf` is 1 exactly when `a` and `b` differ in sign and the result's sign differs from that of `a`.
- R9: `ovf` is 0 for AND, OR and set-on-less-than.
- R10: The unused codes 3'b011, 3'b100 and 3'b101 return an all-zero result with `ovf` 0, so `zero` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 3 | Operation select |
| y | output | WIDTH | Result word |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block with the default WIDTH of 32. At that width the most-negative and most-positive words, 32'h8000_0000 and 32'h7FFF_FFFF, can be driven directly. These values exercise both overflow directions in add and subtract. They also exercise the set-on-less-than cases where the raw sign of the difference is wrong and must be corrected. The expected results come from a wide signed reference model. It reaches equal operands, which give a zero difference, and every unused operation code.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] y,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic             invert_b;
  logic [WIDTH-1:0] b_in;
  logic [MSB-1:0]   low_sum;
  logic             carry_top;
  logic             top_sum;
  logic             carry_out;
  logic [WIDTH-1:0] sum;
  logic             arith_ovf;
  logic             less;

  assign invert_b = op[2];
  assign b_in     = invert_b ? ~b : b;

  assign {carry_top, low_sum} = {1'b0, a[MSB-1:0]} + {1'b0, b_in[MSB-1:0]}
                              + {{(MSB){1'b0}}, invert_b};
  assign {carry_out, top_sum} = {1'b0, a[MSB]} + {1'b0, b_in[MSB]} + {1'b0, carry_top};
  assign sum       = {top_sum, low_sum};
  assign arith_ovf = carry_top ^ carry_out;
  assign less      = top_sum ^ arith_ovf;

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (op)
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_ADD: begin y = sum; ovf = arith_ovf; end
      OP_SUB: begin y = sum; ovf = arith_ovf; end
      OP_SLT: y = {{(MSB){1'b0}}, less};
      default: y = '0;
    endcase
  end

  assign zero = ~|y;
endmodule

// File: rtl/int_alu_props.sv
module int_alu_props #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] y,
  input logic             zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (op == 3'b111) begin
      p_slt_signed_r5: assert (y[0] == ($signed(a) < $signed(b)));
      p_slt_upper_r5:  assert (y[MSB:1] == '0);
    end
    if (op == 3'b110)
      p_sub_eq_zero_r6: assert (zero == (a == b));
    if (op == 3'b010)
      p_add_ovf_r7: assert (ovf == ((a[MSB] == b[MSB]) && (y[MSB] != a[MSB])));
    if (op == 3'b110)
      p_sub_ovf_r8: assert (ovf == ((a[MSB] != b[MSB]) && (y[MSB] != a[MSB])));
    if (op == 3'b000 || op == 3'b001 || op == 3'b111)
      p_no_overflow_r9: assert (!ovf);
    if (op == 3'b011 || op == 3'b100 || op == 3'b101)
      p_unused_r10: assert (zero && !ovf);
  end
endmodule

bind int_alu int_alu_props #(.WIDTH(WIDTH)) u_props (
  .a(a), .b(b), .op(op), .y(y), .zero(zero), .ovf(ovf)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  localparam int W = 32;

  typedef struct {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] y;
    logic         z;
    logic         v;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] y;
  logic         zero;
  logic         ovf;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  int_alu #(.WIDTH(W)) u_int_alu (
    .a(a), .b(b), .op(op), .y(y), .zero(zero), .ovf(ovf)
  );

  function automatic item_t model(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] w, string tag);
    item_t it;
    longint sx, sw, r;
    sx = longint'($signed(x));
    sw = longint'($signed(w));
    it.op = o; it.a = x; it.b = w; it.tag = tag;
    it.y = '0; it.v = 1'b0;
    case (o)
      3'b000: it.y = x & w;
      3'b001: it.y = x | w;
      3'b010: begin r = sx + sw; it.y = r[W-1:0]; it.v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
      3'b110: begin r = sx - sw; it.y = r[W-1:0]; it.v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
      3'b111: it.y = (sx < sw) ? 1 : 0;
      default: it.y = '0;
    endcase
    it.z = (it.y == '0);
    return it;
  endfunction

  task automatic drive(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] w, string tag);
    @(posedge clk);
    #1;
    op = o; a = x; b = w;
    q.push_back(model(o, x, w, tag));
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (y !== it.y || zero !== it.z || ovf !== it.v) begin
          errors++;
          $display("FAIL %s op=%b a=%h b=%h actual y=%h z=%b v=%b expected y=%h z=%b v=%b",
                   it.tag, it.op, it.a, it.b, y, zero, ovf, it.y, it.z, it.v);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: all-zero AND gives zero flag (R1, R6)
    drive(3'b000, '0, '0, "R1_idle");
    drive(3'b000, 32'hF0F0_1234, 32'h0FF0_FF00, "R1");
    drive(3'b001, 32'hF0F0_1234, 32'h0FF0_FF00, "R2");
    drive(3'b001, 32'h0, 32'h0, "R2_R6");
    drive(3'b010, 32'd7, 32'd9, "R3");
    drive(3'b010, 32'hFFFF_FFFF, 32'd1, "R3_wrap_R6");
    drive(3'b010, 32'h7FFF_FFFF, 32'd1, "R7_pos");
    drive(3'b010, 32'h8000_0000, 32'h8000_0000, "R7_neg");
    drive(3'b010, 32'h7FFF_FFFF, 32'h8000_0000, "R7_mixed");
    drive(3'b110, 32'd10, 32'd3, "R4");
    drive(3'b110, 32'd3, 32'd10, "R4_neg");
    drive(3'b110, 32'h1234_5678, 32'h1234_5678, "R6_equal");
    drive(3'b110, 32'h8000_0000, 32'd1, "R8_neg");
    drive(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8_pos");
    drive(3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R8_same");
    drive(3'b111, 32'd1, 32'd2, "R5_lt");
    drive(3'b111, 32'd2, 32'd1, "R5_gt");
    drive(3'b111, 32'd5, 32'd5, "R5_eq");
    drive(3'b111, 32'hFFFF_FFFF, 32'd0, "R5_signed");
    drive(3'b111, 32'h8000_0000, 32'd1, "R5_ovf_lt");
    drive(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, "R5_ovf_gt_R9");
    drive(3'b000, 32'h8000_0000, 32'h8000_0000, "R9_and");
    drive(3'b011, 32'hFFFF_FFFF, 32'd1, "R10_011");
    drive(3'b100, 32'h7FFF_FFFF, 32'd1, "R10_100");
    drive(3'b101, 32'h8000_0000, 32'h8000_0000, "R10_101");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] x, w;
      x = W'(32'h9E37_79B9 * (i + 1));
      w = W'(32'h85EB_CA6B * (i + 3));
      drive(3'b010, x, w, "R3_R7_sweep");
      drive(3'b110, x, w, "R4_R8_sweep");
      drive(3'b111, x, w, "R5_sweep");
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule